// File: doc/BRIEF.md
# Framed Three-Bit Pattern Detector

This block watches a serial bit stream that arrives one bit per clock when a valid strobe is high. It cuts the accepted bits into back-to-back groups of three, with no overlap. A group whose last two bits are a one followed by a zero (the groups 010 and 110) raises the detect output for exactly one clock. Every other group leaves detect low. Once the third bit of a group has been taken, the machine is back at its start state, ready for the next group.

The machine is a Mealy machine cut down to four states. The first bit of a group never decides the result, so one state covers "one bit seen". After two bits only the second bit matters, so two states cover that step. The hit is found from the current state and the incoming bit, then stored in a flop. Detect therefore appears in the cycle after the third bit is taken, as a clean single-cycle pulse. Cycles with the strobe low do not advance the group, so bits may arrive with gaps of any length.

Top module: `frame_det_top`

## Requirements
- R1: While rst is high at a rising clock edge, the machine goes to its start state and detect is low in the following cycle; a bit presented with in_valid high during reset is not counted.
- R2: A bit is taken only at a rising edge where in_valid is 1; with in_valid low the group position holds and detect is 0 in the next cycle.
- R3: Accepted bits form consecutive, non-overlapping groups of three; the first bit taken after reset starts a group, and gaps between bits do not split a group.
- R4: When the third bit of a group is taken, detect is 1 in the next cycle if the group, oldest bit first, is 010 or 110.
- R5: The groups 000, 001, 011, 100, 101 and 111 give detect 0, and a 010 or 110 run that straddles two groups gives no detect.
- R6: Detect is never high in two consecutive cycles.
- R7: A reset in the middle of a group discards the partial group; the next accepted bit is the first bit of a new group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when in_bit carries a stream bit this cycle |
| in_bit | input | 1 | Serial stream bit |
| detect | output | 1 | One-cycle pulse after a group ending in 1 then 0 |

## Verification
With the strobe held high, the detect pulse for one group appears in the same cycle that the first bit of the next group is taken. The bench streams groups with no gaps, so a wrongly timed pulse, or a start state that misses this handover, shows up in the following group's result. Reset is also asserted while the strobe is high and while a group is half done. The bench checks that the bit presented during reset is dropped and that counting starts again from position zero. Each accepted bit is judged against a model of the group position kept in the bench, and every idle cycle must show detect low.

// File: rtl/frame_det_pkg.sv
package frame_det_pkg;

  localparam int STATE_W = 2;

  // start state must be all zeros
  typedef enum logic [STATE_W-1:0] {
    ST_START  = 2'b00,
    ST_ONE    = 2'b01,
    ST_TWO_LO = 2'b10,
    ST_TWO_HI = 2'b11
  } fd_state_t;

  function automatic fd_state_t fd_next(input fd_state_t s, input logic b);
    fd_state_t n;
    case (s)
      ST_START: n = ST_ONE;
      ST_ONE:   n = b ? ST_TWO_HI : ST_TWO_LO;
      default:  n = ST_START;
    endcase
    return n;
  endfunction

  function automatic logic fd_hit(input fd_state_t s, input logic b);
    return (s == ST_TWO_HI) && !b;
  endfunction

endpackage

// File: rtl/frame_det_logic.sv
module frame_det_logic
  import frame_det_pkg::*;
(
  input  fd_state_t cur_state,
  input  logic      in_valid,
  input  logic      in_bit,
  output fd_state_t nxt_state,
  output logic      take,
  output logic      hit_now
);
  always_comb begin
    take      = in_valid;
    nxt_state = in_valid ? fd_next(cur_state, in_bit) : cur_state;
    hit_now   = in_valid && fd_hit(cur_state, in_bit);
  end
endmodule

// File: rtl/frame_det_reg.sv
module frame_det_reg
  import frame_det_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  fd_state_t nxt_state,
  input  logic      hit_now,
  output fd_state_t cur_state,
  output logic      detect
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_state <= ST_START;
      detect    <= 1'b0;
    end else begin
      cur_state <= nxt_state;
      detect    <= hit_now;
    end
  end
endmodule

// File: rtl/frame_det_top.sv
module frame_det_top
  import frame_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic detect
);
  fd_state_t cur_state;
  fd_state_t nxt_state;
  logic      take;
  logic      hit_now;

  frame_det_logic u_logic (
    .cur_state(cur_state),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .nxt_state(nxt_state),
    .take     (take),
    .hit_now  (hit_now)
  );

  frame_det_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .nxt_state(nxt_state),
    .hit_now  (hit_now),
    .cur_state(cur_state),
    .detect   (detect)
  );
endmodule

// File: rtl/frame_det_chk.sv
module frame_det_chk
  import frame_det_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      in_valid,
  input logic      in_bit,
  input logic      take,
  input fd_state_t cur_state,
  input logic      detect
);
  // R1
  reset_start_chk: assert property (@(posedge clk)
    rst |=> (cur_state == ST_START && !detect));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(cur_state) && !detect));

  // R3
  group_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (take && (cur_state == ST_TWO_LO || cur_state == ST_TWO_HI)) |=> cur_state == ST_START);

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (take && cur_state == ST_START) |=> cur_state == ST_ONE);

  // R4
  detect_cause_chk: assert property (@(posedge clk) disable iff (rst)
    detect |-> $past(in_valid && cur_state == ST_TWO_HI && !in_bit));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    detect |=> !detect);
endmodule

bind frame_det_top frame_det_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_bit   (in_bit),
  .take     (take),
  .cur_state(cur_state),
  .detect   (detect)
);

// File: tb/frame_det_top_tb_top.sv
module frame_det_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic detect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model: position in group and previous bit
  int   pos = 0;
  logic prv = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  logic acc_prev = 1'b0;
  logic rst_prev = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_det_top dut_i (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_bit  (in_bit),
    .detect  (detect)
  );

  task automatic send_bit(input logic b, input string tag);
    logic e;
    @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    e = (pos == 2) && prv && !b;
    prv = b;
    pos = (pos == 2) ? 0 : pos + 1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic do_reset(input int n, input logic valid_during);
    @(negedge clk);
    rst = 1'b1;
    in_valid = valid_during;
    in_bit = 1'b1;
    pos = 0;
    prv = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic send_group(input logic [2:0] g, input string tag);
    send_bit(g[2], tag);
    send_bit(g[1], tag);
    send_bit(g[0], tag);
  endtask

  // monitor
  always @(posedge clk) begin
    acc_prev <= in_valid && !rst;
    rst_prev <= rst;
  end

  always @(negedge clk) begin
    if (acc_prev) begin
      logic e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (detect !== e) begin
        errors++;
        $display("FAIL %s detect=%b expected=%b at %0t", t, detect, e, $time);
      end
    end else begin
      checks++;
      if (detect !== 1'b0) begin
        errors++;
        $display("FAIL %s detect=%b expected=0 at %0t", rst_prev ? "R1" : "R2", detect, $time);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: bits offered during reset must be dropped
    do_reset(3, 1'b1);
    // R4: both hit groups, back to back
    send_group(3'b010, "R4");
    send_group(3'b110, "R4");
    // R5: every non-hit group
    send_group(3'b000, "R5");
    send_group(3'b001, "R5");
    send_group(3'b011, "R5");
    send_group(3'b100, "R5");
    send_group(3'b101, "R5");
    send_group(3'b111, "R5");
    // R5: straddling run 1,0 across group boundary
    send_group(3'b001, "R5");
    send_group(3'b011, "R5");
    send_group(3'b010, "R6");
    send_group(3'b110, "R6");
    // R2/R3: gaps inside a group
    send_bit(1'b1, "R3");
    idle(4);
    send_bit(1'b1, "R3");
    idle(2);
    send_bit(1'b0, "R3");
    idle(3);
    // R7: reset mid group
    send_bit(1'b0, "R7");
    send_bit(1'b1, "R7");
    do_reset(1, 1'b0);
    send_group(3'b010, "R7");
    // R1 with valid high during reset, mid group
    send_bit(1'b1, "R1");
    do_reset(2, 1'b1);
    send_group(3'b110, "R1");
    // random streams with random gaps
    for (int i = 0; i < 600; i++) begin
      send_bit(1'($urandom_range(0, 1)), "R3");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule